// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a serial-out shift register with a parameterised number of stages. The default is eight. It takes its contents in one of two ways: a word loaded broadside from a parallel input, or bits shifted in one at a time from a serial input. Only the final stage drives the output pin. A mode input chooses between shifting and loading. A hold input freezes the register on any cycle. An active-low clear forces every stage to zero at once.

The system clock runs freely. Gating is done as a synchronous enable that is sampled on each rising edge, so the design never builds a gated clock net. The clear takes effect asynchronously when it is asserted. Its release is retimed through two flops, so the register only starts shifting or loading cleanly, a known number of edges after the release.

Top module: `gcpl_shreg`

## Requirements
- R1: On an active edge with `shift_mode` high, `ser_in` enters the first stage and every other stage takes the old value of the stage before it.
- R2: On an active edge with `shift_mode` low, each `par_in[i]` is copied into stage i. Bit 0 is the first stage and bit DEPTH-1 is the last. The copy is synchronous and appears only after that edge.
- R3: During a parallel load, `ser_in` has no influence on any stage.
- R4: On any edge where `hold` is high, all stages keep their values, whatever `shift_mode`, `ser_in` and `par_in` are.
- R5: While `clr_n` is low, every stage is zero. This takes effect without waiting for a clock edge and overrides `hold` and `shift_mode`.
- R6: After `clr_n` rises, the first two rising clock edges leave the register at zero. Shifting or loading starts from the third edge.
- R7: `ser_out` always shows the content of the last stage. Data loaded into stage i therefore reaches `ser_out` after DEPTH-1-i further shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, rising edge active |
| clr_n | input | 1 | Active-low clear; asynchronous assert, synchronised release |
| hold | input | 1 | High freezes all stages on that edge |
| shift_mode | input | 1 | High selects serial shift, low selects parallel load |
| ser_in | input | 1 | Serial data entering the first stage |
| par_in | input | DEPTH | Parallel word; bit i loads stage i |
| ser_out | output | 1 | Content of the last stage |

## Verification
The properties assume that `hold`, `shift_mode`, `ser_in` and `par_in` are stable around each rising edge. This is the synchronous form of the rule that the inhibit input may only change while the clock is high. The properties also assume that `clr_n` may fall at any time but is released away from the edge. The stimulus follows these assumptions: it changes every data and control input on the falling edge, and it releases the clear on a falling edge too. One directed case drops `clr_n` halfway through the high phase, in the middle of a shift run, so that the asynchronous clear can be seen before the next edge.

// File: rtl/gcpl_shreg.sv
module gcpl_shreg #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             hold,
  input  logic             shift_mode,
  input  logic             ser_in,
  input  logic [DEPTH-1:0] par_in,
  output logic             ser_out
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage;
  logic [1:0]       arm;
  logic             run;

  // release retiming: clear drops arm at once, arm refills one bit per edge
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) arm <= '0;
    else        arm <= {arm[0], 1'b1};
  end

  assign run = arm[1];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      stage <= '0;
    else if (run && !hold)
      stage <= shift_mode ? {stage[LAST-1:0], ser_in} : par_in;
  end

  assign ser_out = stage[LAST];

  p_shift_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (run && !hold && shift_mode) |=> ser_out == $past(stage[LAST-1]));

  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (run && !hold && !shift_mode) |=> stage == $past(par_in));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    hold |=> $stable(stage));

  p_clear_r5: assert property (@(posedge clk)
    !clr_n |-> (stage == '0 && ser_out == 1'b0));

  p_release_r6: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |=> stage == '0);

endmodule

// File: tb/gcpl_shreg_tb.sv
`timescale 1ns/1ps
module gcpl_shreg_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic hold = 1'b0;
  logic shift_mode = 1'b0;
  logic ser_in = 1'b0;
  logic [DEPTH-1:0] par_in = '0;
  logic ser_out;

  gcpl_shreg #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .clr_n(clr_n), .hold(hold), .shift_mode(shift_mode),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  logic [DEPTH-1:0] m_stage = '0;
  logic [1:0]       m_arm = '0;

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: ser_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: set inputs for the next edge, advance the model, queue the expected output
  task automatic drive(input bit c, input bit h, input bit m, input bit s,
                       input logic [DEPTH-1:0] p, input string tag);
    @(negedge clk);
    clr_n = c; hold = h; shift_mode = m; ser_in = s; par_in = p;
    if (!c) begin
      m_stage = '0; m_arm = '0;
    end else begin
      if (m_arm[1] && !h) m_stage = m ? {m_stage[DEPTH-2:0], s} : p;
      m_arm = {m_arm[0], 1'b1};
    end
    exp_q.push_back(m_stage[DEPTH-1]);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(ser_out, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: expired, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2;
    check(ser_out, 1'b0, "R5 reset state");
    drive(0, 0, 0, 1, '1, "R5");
    // release: two edges with load of ones must leave zeros
    drive(1, 0, 0, 1, '1, "R6");
    drive(1, 0, 0, 1, '1, "R6");
    // third edge loads pattern with ser_in high (R3 ignored)
    drive(1, 0, 0, 1, 8'b0101_1001, "R2");
    // hold with all other inputs moving
    for (int k = 0; k < 4; k++) drive(1, 1, k[0], 1, 8'h00, "R4");
    // shift pattern out, zeros behind it
    for (int k = 0; k < DEPTH; k++) drive(1, 0, 1, 0, '1, "R7");
    // load ones-with-gap, ser_in toggling; then shift
    drive(1, 0, 0, 0, 8'b1000_0001, "R3");
    for (int k = 0; k < DEPTH; k++) drive(1, 0, 1, 1, '0, "R1");
    // clear in middle of a shift
    drive(1, 0, 1, 1, '0, "R1");
    @(posedge clk); #2;
    clr_n = 1'b0;
    #1;
    check(ser_out, 1'b0, "R5 async clear mid-shift");
    drive(0, 0, 1, 1, '1, "R5");
    drive(1, 0, 1, 1, '1, "R6");
    drive(1, 0, 1, 1, '1, "R6");
    for (int k = 0; k < DEPTH; k++) drive(1, 0, 1, 1, '0, "R1");
    // randomised patterns
    for (int k = 0; k < 3000; k++) begin
      bit h, m, s, c;
      logic [DEPTH-1:0] p;
      h = ($urandom % 4) == 0;
      m = ($urandom % 3) != 0;
      s = $urandom % 2;
      p = DEPTH'($urandom);
      c = ($urandom % 200) != 0;
      drive(c, h, m, s, p, !c ? "R5" : h ? "R4" : m ? "R1" : "R2");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule